// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test access port for a memory device's pins. A four-wire style interface (test clock, mode select, serial in, serial out) walks a sixteen-state controller. That controller selects and shifts either a 3-bit instruction register or one of three data registers: a 1-bit bypass stage, a 32-bit identification word and a 109-cell boundary chain. The port has no dedicated reset pin. A synchronous active-high power-on reset, or five consecutive rising test-clock edges with mode select high, bring the controller to its reset state, and that state reloads the identification instruction.

The surrounding chip feeds the current pad values into `pin_capture`. It uses `pads_hiz` to float every memory output, and it uses `bsr_drive` together with `bsr_update` to make the output drivers present values loaded through the chain. The serial output changes on the falling test-clock edge. It is enabled only while a register is being shifted.

Top module: `scan_port`

## Requirements
- R1: While `por` is high at a rising `tck` edge, the controller goes to its reset state and the current instruction becomes 001 (identification). After that edge `tdo_oe`, `pads_hiz` and `bsr_drive` are 0 and `bsr_update` is all zeros.
- R2: The controller follows the standard sixteen-state walk on `tms` sampled at rising `tck`. Five consecutive rising edges with `tms` high reach the reset state from any state.
- R3: Every rising edge taken in the reset state loads instruction 001, which cancels any float or drive mode.
- R4: Instruction decode: 000 external test, 010 sample-and-float and 100 sample/preload select the boundary chain. 001 selects the identification word. 111 and the unused codes 011, 101 and 110 select the bypass stage.
- R5: Capture-IR loads 001 into the instruction shifter. Shift-IR moves it toward `tdo` one bit per edge, LSB first, with `tdi` entering at bit 2. Update-IR makes the shifted value current.
- R6: The identification word is 1 in bit 0 and the vendor code in [11:1]. Bits [28:12] hold the type field: [28:20] zero, then density [19:17], organization [16:15], quad-rate flag [14], four-beat flag [13] and separate-I/O flag [12]. The revision is in [31:29]. The word is shifted out LSB first.
- R7: The bypass stage captures 0 and delays `tdi` by exactly one shift.
- R8: With the boundary chain selected, Capture-DR loads `pin_capture` and Shift-DR shifts it LSB first with `tdi` into bit 108. Update-DR copies the chain to `bsr_update`, which changes at no other time.
- R9: `pads_hiz` is 1 exactly while the current instruction is 010.
- R10: `bsr_drive` is 1 exactly while the current instruction is 000. It rises on the Update-IR edge that loads that instruction.
- R11: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is 1 only in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Synchronous active-high power-on reset |
| tms | input | 1 | Mode select, sampled at rising `tck` |
| tdi | input | 1 | Serial data in |
| pin_capture | input | 109 | Pad values loaded by Capture-DR |
| tdo | output | 1 | Serial data out, launched at falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| pads_hiz | output | 1 | Force all memory outputs to high impedance |
| bsr_drive | output | 1 | Pads drive `bsr_update` instead of functional data |
| bsr_update | output | 109 | Values presented by the boundary cells |

## Verification
The bench instantiates the block with its default parameters: a 109-cell chain and the default identification fields. Every cell of the chain can therefore be captured, shifted fully through and updated. The identification word can be compared bit for bit against a value built in the bench from the field layout. The reference model follows every edge, including walks through the pause states. With these defaults the tests reach the five-ones escape from a deep data shift and from a paused instruction shift, where an unintended Update-IR lies on the path.

// File: rtl/scan_port_pkg.sv
`timescale 1ns/1ps
package scan_port_pkg;

    localparam int OP_W = 3;
    localparam int ID_W = 32;

    typedef logic [OP_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST = 3'b000;
    localparam opcode_t OP_IDCODE = 3'b001;
    localparam opcode_t OP_SAMPZ  = 3'b010;
    localparam opcode_t OP_SAMPLE = 3'b100;
    localparam opcode_t OP_BYPASS = 3'b111;
    localparam opcode_t CAPIR_PAT = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

    typedef struct packed {
        logic [8:0] spare;
        logic [2:0] density;
        logic [1:0] org;
        logic       quad_rate;
        logic       four_beat;
        logic       sep_io;
    } type_field_t;

    typedef struct packed {
        logic [2:0]  rev;
        type_field_t kind;
        logic [10:0] vendor;
        logic        one;
    } id_word_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            TS_RESET:    return tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:     return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR:   return tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR:   return tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:    return tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR:   return tms ? TS_UPD_DR : TS_PAUSE_DR;
            TS_PAUSE_DR: return tms ? TS_EX2_DR : TS_PAUSE_DR;
            TS_EX2_DR:   return tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR:   return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR:   return tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR:   return tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:    return tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR:   return tms ? TS_UPD_IR : TS_PAUSE_IR;
            TS_PAUSE_IR: return tms ? TS_EX2_IR : TS_PAUSE_IR;
            TS_EX2_IR:   return tms ? TS_UPD_IR : TS_SH_IR;
            default:     return tms ? TS_SEL_DR : TS_IDLE;
        endcase
    endfunction

    function automatic dr_sel_e decode_op(input opcode_t op);
        case (op)
            OP_EXTEST, OP_SAMPZ, OP_SAMPLE: return SEL_BSR;
            OP_IDCODE:                      return SEL_ID;
            default:                        return SEL_BYP;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] make_id(
        input logic [2:0]  rev,
        input logic [2:0]  density,
        input logic [1:0]  org,
        input logic        quad_rate,
        input logic        four_beat,
        input logic        sep_io,
        input logic [10:0] vendor
    );
        id_word_t w;
        w.rev             = rev;
        w.kind.spare      = '0;
        w.kind.density    = density;
        w.kind.org        = org;
        w.kind.quad_rate  = quad_rate;
        w.kind.four_beat  = four_beat;
        w.kind.sep_io     = sep_io;
        w.vendor          = vendor;
        w.one             = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/scan_port_fsm.sv
`timescale 1ns/1ps
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (por) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // run length of consecutive high mode-select samples, saturating
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (por)                  ones_run <= '0;
        else if (!tms)            ones_run <= '0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (por)
        (ones_run == 3'd5) |-> (state == TS_RESET))
        else $error("five high tms samples did not reach reset state");

endmodule

// File: rtl/scan_port_ir.sv
`timescale 1ns/1ps
module scan_port_ir
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  logic       tdi,
    input  tap_state_e state,
    output opcode_t    ir,
    output logic       ir_lsb
);

    opcode_t ir_sh;

    always_ff @(posedge tck) begin
        if (por) begin
            ir_sh <= '0;
        end else if (state == TS_CAP_IR) begin
            ir_sh <= CAPIR_PAT;
        end else if (state == TS_SH_IR) begin
            ir_sh <= {tdi, ir_sh[OP_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (por || state == TS_RESET) ir <= OP_IDCODE;
        else if (state == TS_UPD_IR)  ir <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

    assert_reset_loads_id_R3: assert property (@(posedge tck) disable iff (por)
        (state == TS_RESET) |=> (ir == OP_IDCODE))
        else $error("reset state did not restore identification instruction");

    assert_capture_pattern_R5: assert property (@(posedge tck) disable iff (por)
        (state == TS_CAP_IR) |=> (ir_sh == CAPIR_PAT))
        else $error("instruction capture pattern wrong");

    assert_ir_change_point_R5: assert property (@(posedge tck) disable iff (por)
        !$stable(ir) |-> ($past(state) == TS_UPD_IR || $past(state) == TS_RESET))
        else $error("instruction changed outside update or reset");

endmodule

// File: rtl/scan_port_dr.sv
`timescale 1ns/1ps
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int              BSR_LEN  = 109,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               por,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic [BSR_LEN-1:0] bsr_update,
    output logic               dr_lsb
);

    logic [BSR_LEN-1:0] bsr_sh;
    logic [ID_W-1:0]    id_sh;
    logic               byp_sh;

    always_ff @(posedge tck) begin
        if (por) begin
            bsr_sh     <= '0;
            id_sh      <= '0;
            byp_sh     <= 1'b0;
            bsr_update <= '0;
        end else begin
            case (state)
                TS_CAP_DR: begin
                    case (sel)
                        SEL_BSR: bsr_sh <= pin_capture;
                        SEL_ID:  id_sh  <= ID_VALUE;
                        default: byp_sh <= 1'b0;
                    endcase
                end
                TS_SH_DR: begin
                    case (sel)
                        SEL_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
                        SEL_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
                        default: byp_sh <= tdi;
                    endcase
                end
                TS_UPD_DR: begin
                    if (sel == SEL_BSR) bsr_update <= bsr_sh;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_BSR: dr_lsb = bsr_sh[0];
            SEL_ID:  dr_lsb = id_sh[0];
            default: dr_lsb = byp_sh;
        endcase
    end

    assert_update_point_R8: assert property (@(posedge tck) disable iff (por)
        !$stable(bsr_update) |-> ($past(state) == TS_UPD_DR))
        else $error("boundary update values changed outside Update-DR");

endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
    import scan_port_pkg::*;
#(
    parameter int          BSR_LEN    = 109,
    parameter logic [2:0]  ID_REV     = 3'd1,
    parameter logic [2:0]  ID_DENSITY = 3'd2,
    parameter logic [1:0]  ID_ORG     = 2'd3,
    parameter logic        ID_QUAD    = 1'b1,
    parameter logic        ID_FOUR    = 1'b1,
    parameter logic        ID_SEPIO   = 1'b1,
    parameter logic [10:0] ID_VENDOR  = 11'h0A3
) (
    input  logic               tck,
    input  logic               por,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               pads_hiz,
    output logic               bsr_drive,
    output logic [BSR_LEN-1:0] bsr_update
);

    localparam logic [ID_W-1:0] ID_WORD =
        make_id(ID_REV, ID_DENSITY, ID_ORG, ID_QUAD, ID_FOUR, ID_SEPIO, ID_VENDOR);

    tap_state_e state;
    opcode_t    ir;
    logic       ir_lsb;
    logic       dr_lsb;
    dr_sel_e    sel;

    scan_port_fsm u_fsm (
        .tck   (tck),
        .por   (por),
        .tms   (tms),
        .state (state)
    );

    scan_port_ir u_ir (
        .tck    (tck),
        .por    (por),
        .tdi    (tdi),
        .state  (state),
        .ir     (ir),
        .ir_lsb (ir_lsb)
    );

    assign sel = decode_op(ir);

    scan_port_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_WORD)
    ) u_dr (
        .tck         (tck),
        .por         (por),
        .tdi         (tdi),
        .state       (state),
        .sel         (sel),
        .pin_capture (pin_capture),
        .bsr_update  (bsr_update),
        .dr_lsb      (dr_lsb)
    );

    logic in_shift_ir;
    logic in_shift_dr;
    assign in_shift_ir = (state == TS_SH_IR);
    assign in_shift_dr = (state == TS_SH_DR);

    // serial output launched on the falling edge
    always_ff @(negedge tck) begin
        if (por) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift_ir | in_shift_dr;
            tdo    <= in_shift_ir ? ir_lsb : (in_shift_dr ? dr_lsb : 1'b0);
        end
    end

    assign pads_hiz  = (ir == OP_SAMPZ);
    assign bsr_drive = (ir == OP_EXTEST);

    assert_oe_only_shift_R11: assert property (@(posedge tck) disable iff (por)
        tdo_oe |-> (state == TS_SH_IR || state == TS_SH_DR))
        else $error("serial output enabled outside a shift state");

    assert_tdo_low_idle_R11: assert property (@(posedge tck) disable iff (por)
        !tdo_oe |-> !tdo)
        else $error("serial output not low while disabled");

    assert_hiz_on_update_R9: assert property (@(posedge tck) disable iff (por)
        $rose(pads_hiz) |-> ($past(state) == TS_UPD_IR))
        else $error("float mode entered outside Update-IR");

    assert_drive_on_update_R10: assert property (@(posedge tck) disable iff (por)
        $rose(bsr_drive) |-> ($past(state) == TS_UPD_IR))
        else $error("drive mode entered outside Update-IR");

endmodule

// File: tb/tb_scan_port.sv
`timescale 1ns/1ps
module tb_scan_port;

    localparam int N = 109;
    localparam logic [31:0] ID_EXP = {3'd1, 9'd0, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 11'h0A3, 1'b1};

    localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4, M_X1DR = 5,
                   M_PDR = 6, M_X2DR = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHIR = 11,
                   M_X1IR = 12, M_PIR = 13, M_X2IR = 14, M_UIR = 15;

    logic         tck = 1'b0;
    logic         por = 1'b1;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pins = '0;
    logic         tdo, tdo_oe, pads_hiz, bsr_drive;
    logic [N-1:0] bsr_update;

    int errors = 0;
    int checks = 0;

    // reference model state
    int           ms;
    logic [2:0]   mir, mirsh;
    logic         mbyp;
    logic [31:0]  mid;
    logic [N-1:0] mbsr, mupd;

    scan_port dut (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .pin_capture(pins),
        .tdo(tdo), .tdo_oe(tdo_oe), .pads_hiz(pads_hiz), .bsr_drive(bsr_drive),
        .bsr_update(bsr_update)
    );

    always #2.5 tck = ~tck;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mnext(input int s, input logic t);
        case (s)
            M_TLR:  return t ? M_TLR : M_RTI;
            M_RTI:  return t ? M_SDR : M_RTI;
            M_SDR:  return t ? M_SIR : M_CDR;
            M_CDR:  return t ? M_X1DR : M_SHDR;
            M_SHDR: return t ? M_X1DR : M_SHDR;
            M_X1DR: return t ? M_UDR : M_PDR;
            M_PDR:  return t ? M_X2DR : M_PDR;
            M_X2DR: return t ? M_UDR : M_SHDR;
            M_UDR:  return t ? M_SDR : M_RTI;
            M_SIR:  return t ? M_TLR : M_CIR;
            M_CIR:  return t ? M_X1IR : M_SHIR;
            M_SHIR: return t ? M_X1IR : M_SHIR;
            M_X1IR: return t ? M_UIR : M_PIR;
            M_PIR:  return t ? M_X2IR : M_PIR;
            M_X2IR: return t ? M_UIR : M_SHIR;
            default: return t ? M_SDR : M_RTI;
        endcase
    endfunction

    // 2 boundary, 1 identification, 0 bypass (R4)
    function automatic int msel();
        if (mir == 3'b000 || mir == 3'b010 || mir == 3'b100) return 2;
        if (mir == 3'b001) return 1;
        return 0;
    endfunction

    task automatic model_step(input logic t, input logic d);
        int s;
        s = msel();
        case (ms)
            M_TLR:  mir = 3'b001;
            M_CIR:  mirsh = 3'b001;
            M_SHIR: mirsh = {d, mirsh[2:1]};
            M_UIR:  mir = mirsh;
            M_CDR: begin
                if (s == 2) mbsr = pins;
                else if (s == 1) mid = ID_EXP;
                else mbyp = 1'b0;
            end
            M_SHDR: begin
                if (s == 2) mbsr = {d, mbsr[N-1:1]};
                else if (s == 1) mid = {d, mid[31:1]};
                else mbyp = d;
            end
            M_UDR: if (s == 2) mupd = mbsr;
            default: ;
        endcase
        ms = mnext(ms, t);
    endtask

    task automatic tick(input logic t, input logic d);
        logic pre;
        logic exp_oe, exp_tdo;
        int s;
        tms = t;
        tdi = d;
        pre = tdo;
        @(posedge tck);
        model_step(t, d);
        #1;
        chk(tdo === pre, "R11 tdo held across rising edge", 128'(tdo), 128'(pre));
        @(negedge tck);
        #1;
        exp_oe = (ms == M_SHIR || ms == M_SHDR);
        chk(tdo_oe === exp_oe, "R11 tdo_oe", 128'(tdo_oe), 128'(exp_oe));
        if (ms == M_SHIR) begin
            chk(tdo === mirsh[0], "R5 instruction shift bit", 128'(tdo), 128'(mirsh[0]));
        end else if (ms == M_SHDR) begin
            s = msel();
            exp_tdo = (s == 2) ? mbsr[0] : ((s == 1) ? mid[0] : mbyp);
            if (s == 2)      chk(tdo === exp_tdo, "R8 boundary shift bit", 128'(tdo), 128'(exp_tdo));
            else if (s == 1) chk(tdo === exp_tdo, "R6 identification shift bit", 128'(tdo), 128'(exp_tdo));
            else             chk(tdo === exp_tdo, "R7 bypass shift bit", 128'(tdo), 128'(exp_tdo));
        end else begin
            chk(tdo === 1'b0, "R11 tdo low while disabled", 128'(tdo), 128'(0));
        end
        chk(pads_hiz === (mir == 3'b010), "R9 pads_hiz", 128'(pads_hiz), 128'(mir == 3'b010));
        chk(bsr_drive === (mir == 3'b000), "R10 bsr_drive", 128'(bsr_drive), 128'(mir == 3'b000));
        chk(bsr_update === mupd, "R8 bsr_update", 128'(bsr_update), 128'(mupd));
    endtask

    task automatic shift_n(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
    endtask

    task automatic leave();
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] seen);
        logic [127:0] o;
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        shift_n(3, 128'(op), o);
        seen = o[2:0];
        leave();
    endtask

    task automatic enter_dr();
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic read_id(input string tag);
        logic [127:0] o;
        enter_dr();
        shift_n(32, 128'(0), o);
        chk(o[31:0] === ID_EXP, tag, 128'(o[31:0]), 128'(ID_EXP));
        leave();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [2:0]   seen;
        logic [127:0] o;
        logic [127:0] pa, pb, pc;
        logic [2:0]   resv [3];
        resv[0] = 3'b011;
        resv[1] = 3'b101;
        resv[2] = 3'b110;

        ms = M_TLR; mir = 3'b001; mirsh = '0; mbyp = 1'b0; mid = '0; mbsr = '0; mupd = '0;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1;
        // R1 reset state
        chk({tdo_oe, pads_hiz, bsr_drive} === 3'b000, "R1 idle outputs after reset",
            128'({tdo_oe, pads_hiz, bsr_drive}), 128'(0));
        chk(bsr_update === '0, "R1 update values cleared", 128'(bsr_update), 128'(0));
        por = 1'b0;
        tick(1'b0, 1'b0);

        // R1 R6: default instruction reads the identification word
        read_id("R6 identification word after reset");

        // R5 capture pattern and bypass (R7)
        load_ir(3'b111, seen);
        chk(seen === 3'b001, "R5 Capture-IR pattern", 128'(seen), 128'(3'b001));
        enter_dr();
        shift_n(8, 128'(8'hB6), o);
        chk(o[7:0] === 8'h6C, "R7 bypass one-shift delay", 128'(o[7:0]), 128'(8'h6C));
        leave();

        // R4 unused codes behave as bypass
        for (int k = 0; k < 3; k++) begin
            load_ir(resv[k], seen);
            enter_dr();
            shift_n(6, 128'(6'b101101), o);
            chk(o[5:0] === 6'b011010, "R4 unused code selects bypass", 128'(o[5:0]), 128'(6'b011010));
            leave();
        end

        // R8 sample/preload
        pa = 128'h1F2E_3D4C_5B6A_7988_9A7B_6C5D_4E3F_2011;
        pb = 128'hC0DE_5A5A_0F0F_1234_8765_FEDC_BA98_3C3C;
        pins = pa[N-1:0];
        load_ir(3'b100, seen);
        enter_dr();
        shift_n(N, pb, o);
        chk(o[N-1:0] === pa[N-1:0], "R8 captured pins", 128'(o[N-1:0]), 128'(pa[N-1:0]));
        leave();
        chk(bsr_update === pb[N-1:0], "R8 update after Update-DR", 128'(bsr_update), 128'(pb[N-1:0]));
        chk(bsr_drive === 1'b0, "R10 no drive under sample/preload", 128'(bsr_drive), 128'(0));

        // R10 external test drives preloaded data
        load_ir(3'b000, seen);
        chk(bsr_drive === 1'b1, "R10 drive after Update-IR", 128'(bsr_drive), 128'(1));
        chk(bsr_update === pb[N-1:0], "R10 preloaded values held", 128'(bsr_update), 128'(pb[N-1:0]));

        // R9 sample-and-float
        pc = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        pins = pc[N-1:0];
        load_ir(3'b010, seen);
        chk(pads_hiz === 1'b1, "R9 float after Update-IR", 128'(pads_hiz), 128'(1));
        enter_dr();
        shift_n(N, pa, o);
        chk(o[N-1:0] === pc[N-1:0], "R4 float instruction captures pins", 128'(o[N-1:0]), 128'(pc[N-1:0]));
        leave();

        // R2 five ones from the middle of a data shift
        enter_dr();
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        repeat (5) tick(1'b1, 1'b0);
        chk(tdo_oe === 1'b0, "R2 left shift after five ones", 128'(tdo_oe), 128'(0));
        tick(1'b0, 1'b0);
        chk(pads_hiz === 1'b0, "R3 reset state cancels float", 128'(pads_hiz), 128'(0));
        read_id("R2 identification after five-ones escape");

        // R2 five ones from a paused instruction shift
        load_ir(3'b000, seen);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        repeat (5) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        chk(bsr_drive === 1'b0, "R3 reset state cancels drive", 128'(bsr_drive), 128'(0));
        read_id("R2 identification after escape from pause");

        summary();
        $finish;
    end

endmodule